// File: doc/BRIEF.md
# Proximity Window Interrupt with Consecutive-Event Filter

This block watches a stream of 16-bit proximity conversion results and decides when the host should be interrupted. Each result arrives with a one-cycle valid strobe. The block compares it against a lower and an upper bound, and each bound is supplied as a pair of bytes. A result above the upper bound or below the lower bound is an out-of-window event.

A small counter tracks how many such events have arrived back to back. A 4-bit persistence setting says how many consecutive events are needed before the block raises its status flag. The flag is sticky until software pulses a clear strobe. The interrupt line is the flag gated by an enable input, so the status can still be polled while the interrupt is masked. A persistence setting of zero disables the filter, and every completed conversion then sets the flag.

Top module: `prox_window_irq`

## Requirements
- R1: The lower bound is {thr_lo_msb, thr_lo_lsb} and the upper bound is {thr_hi_msb, thr_hi_lsb}, with the high byte in bits 15:8. A sample is an event when it is strictly greater than the upper bound or strictly less than the lower bound. A sample equal to either bound is in window.
- R2: Each valid event sample advances the consecutive-event count by one. Each valid in-window sample returns the count to zero.
- R3: With persistence P from 1 to 15, irq_flag is high on the clock edge after the valid sample that completes P consecutive events. It stays low while fewer than P consecutive events have been seen.
- R4: With persistence 0, every valid sample sets irq_flag on the following edge, whether or not it is an event.
- R5: Once set, irq_flag stays high through any further samples until irq_clr is pulsed. The clear takes effect on the next edge.
- R6: irq_clr returns the count to zero. A sample presented in the same cycle as irq_clr is discarded, so it neither counts nor sets the flag.
- R7: irq_o equals irq_flag AND irq_en, without a register in between. irq_flag is set even while irq_en is low.
- R8: Cycles without sample_vld leave the count unchanged, so events separated by idle cycles still count as consecutive.
- R9: The count saturates at 15 rather than wrapping, so a long run of events keeps the persistence condition met.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sample_vld | input | 1 | One-cycle strobe marking a completed conversion |
| sample_data | input | 16 | Conversion result |
| thr_lo_lsb | input | 8 | Lower bound, bits 7:0 |
| thr_lo_msb | input | 8 | Lower bound, bits 15:8 |
| thr_hi_lsb | input | 8 | Upper bound, bits 7:0 |
| thr_hi_msb | input | 8 | Upper bound, bits 15:8 |
| persist_cfg | input | 4 | Consecutive events required; 0 means every conversion |
| irq_en | input | 1 | Interrupt enable |
| irq_clr | input | 1 | Clears the flag and the count |
| irq_o | output | 1 | Level interrupt |
| irq_flag | output | 1 | Sticky status flag |

## Verification
The filter is swept over every persistence value from 0 to 15. For each value, the bench sends runs of 0 to 16 consecutive events, each run ended by an in-window sample. This separates an off-by-one in the count comparison from a counter that fails to reset, and it shows that the zero setting fires on any conversion. The comparator is probed one code below, at and one code above each bound, using unequal bytes so that a swapped byte order shows up as a wrong event. Directed sequences cover the following:
- idle gaps inside a run;
- a clear that coincides with a sample;
- a run longer than the counter range;
- masking the interrupt while the flag is set.

// File: rtl/prox_irq_pkg.sv
package prox_irq_pkg;
  localparam int BYTE_W    = 8;
  localparam int THR_BYTES = 2;
  localparam int DATA_W    = BYTE_W * THR_BYTES;
  localparam int PERS_W    = 4;
  localparam logic [PERS_W-1:0] CNT_MAX = {PERS_W{1'b1}};

  typedef logic [DATA_W-1:0] sample_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [PERS_W-1:0] pcnt_t;

  // True when the sample lies strictly outside [lo, hi]
  function automatic logic is_event(sample_t d, sample_t lo, sample_t hi);
    return (d > hi) || (d < lo);
  endfunction

  // Saturating increment of the consecutive-event count
  function automatic pcnt_t sat_inc(pcnt_t c);
    return (c == CNT_MAX) ? c : pcnt_t'(c + pcnt_t'(1));
  endfunction

  // Persistence condition on the count after the current sample
  function automatic logic persist_met(pcnt_t cfg, pcnt_t cnt_after);
    return (cfg == '0) || (cnt_after >= cfg);
  endfunction
endpackage

// File: rtl/prox_thr_window.sv
module prox_thr_window
  import prox_irq_pkg::*;
(
  input  byte_t   lo_bytes [THR_BYTES],
  input  byte_t   hi_bytes [THR_BYTES],
  input  sample_t data,
  output sample_t lo_bound,
  output sample_t hi_bound,
  output logic    outside
);
  // Byte 0 is least significant; assemble each bound from its bytes
  for (genvar b = 0; b < THR_BYTES; b++) begin : g_byte
    assign lo_bound[b*BYTE_W +: BYTE_W] = lo_bytes[b];
    assign hi_bound[b*BYTE_W +: BYTE_W] = hi_bytes[b];
  end

  assign outside = is_event(data, lo_bound, hi_bound);
endmodule

// File: rtl/prox_persist_cnt.sv
module prox_persist_cnt
  import prox_irq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  take,
  input  logic  outside,
  input  logic  clr,
  output pcnt_t cnt_q,
  output pcnt_t cnt_after
);
  // Count that results if the current sample is accepted
  assign cnt_after = outside ? sat_inc(cnt_q) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (clr)  cnt_q <= '0;
    else if (take) cnt_q <= cnt_after;
  end
endmodule

// File: rtl/prox_irq_latch.sv
module prox_irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic en,
  output logic flag_q,
  output logic irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   flag_q <= 1'b0;
    else if (clr) flag_q <= 1'b0;
    else if (set) flag_q <= 1'b1;
  end

  assign irq = flag_q & en;
endmodule

// File: rtl/prox_window_irq.sv
module prox_window_irq
  import prox_irq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sample_vld,
  input  logic [15:0] sample_data,
  input  logic [7:0]  thr_lo_lsb,
  input  logic [7:0]  thr_lo_msb,
  input  logic [7:0]  thr_hi_lsb,
  input  logic [7:0]  thr_hi_msb,
  input  logic [3:0]  persist_cfg,
  input  logic        irq_en,
  input  logic        irq_clr,
  output logic        irq_o,
  output logic        irq_flag
);
  // Named internal events, visible to the bound checker
  byte_t   lo_bytes [THR_BYTES];
  byte_t   hi_bytes [THR_BYTES];
  sample_t lo_bound, hi_bound;
  logic    sample_evt;
  logic    take;
  logic    fire;
  pcnt_t   cnt_q, cnt_after;

  assign lo_bytes[0] = thr_lo_lsb;
  assign lo_bytes[1] = thr_lo_msb;
  assign hi_bytes[0] = thr_hi_lsb;
  assign hi_bytes[1] = thr_hi_msb;

  // A clear discards any sample in the same cycle
  assign take = sample_vld & ~irq_clr;

  prox_thr_window u_win (
    .lo_bytes (lo_bytes),
    .hi_bytes (hi_bytes),
    .data     (sample_data),
    .lo_bound (lo_bound),
    .hi_bound (hi_bound),
    .outside  (sample_evt)
  );

  prox_persist_cnt u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .take      (take),
    .outside   (sample_evt),
    .clr       (irq_clr),
    .cnt_q     (cnt_q),
    .cnt_after (cnt_after)
  );

  assign fire = take & persist_met(persist_cfg, cnt_after);

  prox_irq_latch u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (fire),
    .clr    (irq_clr),
    .en     (irq_en),
    .flag_q (irq_flag),
    .irq    (irq_o)
  );
endmodule

// File: rtl/prox_window_irq_chk.sv
module prox_window_irq_chk
  import prox_irq_pkg::*;
(
  input logic    clk,
  input logic    rst_n,
  input logic    sample_vld,
  input logic    irq_clr,
  input logic    irq_en,
  input logic    irq_o,
  input logic    irq_flag,
  input logic    sample_evt,
  input pcnt_t   cnt_q,
  input pcnt_t   persist_cfg,
  input sample_t sample_data,
  input sample_t lo_bound,
  input sample_t hi_bound
);
  a_r1_equal_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (sample_data == lo_bound || sample_data == hi_bound) && lo_bound <= hi_bound |-> !sample_evt);

  a_r2_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && !irq_clr && sample_evt && cnt_q != CNT_MAX |=> cnt_q == pcnt_t'($past(cnt_q) + 4'd1));

  a_r2_in_window_zero: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && !irq_clr && !sample_evt |=> cnt_q == '0);

  a_r3_reach_sets: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && !irq_clr && sample_evt && persist_cfg != '0
      && pcnt_t'(cnt_q + 4'd1) == persist_cfg |=> irq_flag);

  a_r4_zero_every: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && !irq_clr && persist_cfg == '0 |=> irq_flag);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && !irq_clr |=> irq_flag);

  a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
    irq_clr |=> !irq_flag && cnt_q == '0);

  a_r7_gate: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o == (irq_flag && irq_en));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !sample_vld && !irq_clr |=> $stable(cnt_q));

  a_r9_saturate: assert property (@(posedge clk) disable iff (!rst_n)
    sample_vld && !irq_clr && sample_evt && cnt_q == CNT_MAX |=> cnt_q == CNT_MAX);
endmodule

bind prox_window_irq prox_window_irq_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .sample_vld  (sample_vld),
  .irq_clr     (irq_clr),
  .irq_en      (irq_en),
  .irq_o       (irq_o),
  .irq_flag    (irq_flag),
  .sample_evt  (sample_evt),
  .cnt_q       (cnt_q),
  .persist_cfg (persist_cfg),
  .sample_data (sample_data),
  .lo_bound    (lo_bound),
  .hi_bound    (hi_bound)
);

// File: tb/prox_window_irq_tb.sv
module prox_window_irq_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sample_vld = 1'b0;
  logic [15:0] sample_data = '0;
  logic [15:0] lo = 16'h1234;
  logic [15:0] hi = 16'h5678;
  logic [3:0]  persist_cfg = '0;
  logic        irq_en = 1'b1;
  logic        irq_clr = 1'b0;
  logic        irq_o, irq_flag;
  int          n_chk = 0;
  int          n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  prox_window_irq u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .sample_vld  (sample_vld),
    .sample_data (sample_data),
    .thr_lo_lsb  (lo[7:0]),
    .thr_lo_msb  (lo[15:8]),
    .thr_hi_lsb  (hi[7:0]),
    .thr_hi_msb  (hi[15:8]),
    .persist_cfg (persist_cfg),
    .irq_en      (irq_en),
    .irq_clr     (irq_clr),
    .irq_o       (irq_o),
    .irq_flag    (irq_flag)
  );

  task automatic check(input logic act, input logic exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", req, act, exp);
    end
  endtask

  // One cycle with a sample; outputs read at the following negedge
  task automatic send(input logic [15:0] d, input logic c);
    @(negedge clk);
    sample_vld = 1'b1; sample_data = d; irq_clr = c;
    @(negedge clk);
    sample_vld = 1'b0; irq_clr = 1'b0;
  endtask

  task automatic clear();
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic ref_event(logic [15:0] d);
    return !(d >= lo && d <= hi);
  endfunction

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [15:0] probe [8];
    repeat (3) @(negedge clk);
    check(irq_flag, 1'b0, "R5 reset flag");
    check(irq_o, 1'b0, "R7 reset irq");
    rst_n = 1'b1;
    idle(2);

    // R3 R4 R2: every persistence value against run lengths 0..16
    for (int p = 0; p < 16; p++) begin
      persist_cfg = 4'(p);
      for (int l = 0; l <= 16; l++) begin
        clear();
        for (int k = 0; k < l; k++) begin
          send(16'(k[0] ? 16'hFFFF : 16'h0000), 1'b0);
          check(irq_flag, (p == 0) || (k + 1 >= p), (p == 0) ? "R4 run" : "R3 run");
        end
        send(16'h3000, 1'b0);
        check(irq_flag, (p == 0) || (l >= p), (p == 0) ? "R4 in-window" : "R2 end-of-run");
      end
    end

    // R2: an in-window sample breaks a run
    persist_cfg = 4'd3;
    clear();
    send(16'h0001, 1'b0); send(16'h0002, 1'b0); send(16'h3000, 1'b0);
    send(16'h0001, 1'b0); send(16'h0002, 1'b0);
    check(irq_flag, 1'b0, "R2 reset by in-window");
    send(16'h0003, 1'b0);
    check(irq_flag, 1'b1, "R2 third consecutive");

    // R1: bound edges, unequal bytes catch a byte swap
    probe[0] = lo - 16'd1; probe[1] = lo; probe[2] = lo + 16'd1;
    probe[3] = hi - 16'd1; probe[4] = hi; probe[5] = hi + 16'd1;
    probe[6] = 16'h0000;   probe[7] = 16'hFFFF;
    persist_cfg = 4'd1;
    for (int i = 0; i < 8; i++) begin
      clear();
      send(probe[i], 1'b0);
      check(irq_flag, ref_event(probe[i]), "R1 bound edge");
    end
    lo = 16'h3412; hi = 16'h7856;
    clear();
    send(16'h2000, 1'b0);
    check(irq_flag, 1'b1, "R1 byte order low");
    clear();
    send(16'h7000, 1'b0);
    check(irq_flag, 1'b0, "R1 byte order high");

    // R8: idle gaps inside a run
    persist_cfg = 4'd3;
    clear();
    send(16'h0000, 1'b0); idle(4); send(16'hFFFF, 1'b0); idle(7);
    check(irq_flag, 1'b0, "R8 two events with gaps");
    send(16'h0000, 1'b0);
    check(irq_flag, 1'b1, "R8 third after gaps");

    // R5: sticky through in-window samples
    send(16'h5000, 1'b0); send(16'h5000, 1'b0); idle(3);
    check(irq_flag, 1'b1, "R5 sticky");
    clear();
    check(irq_flag, 1'b0, "R5 cleared");

    // R6: clear discards a coincident sample and zeroes the count
    persist_cfg = 4'd0;
    send(16'h0000, 1'b1);
    check(irq_flag, 1'b0, "R6 coincident sample dropped");
    persist_cfg = 4'd3;
    send(16'h0000, 1'b0); send(16'h0000, 1'b0);
    clear();
    send(16'h0000, 1'b0);
    check(irq_flag, 1'b0, "R6 count zeroed by clear");
    send(16'h0000, 1'b0); send(16'h0000, 1'b0);
    check(irq_flag, 1'b1, "R6 fresh run of three");

    // R7: enable gates the line, flag still visible
    clear();
    irq_en = 1'b0;
    persist_cfg = 4'd1;
    send(16'hFFFF, 1'b0);
    check(irq_flag, 1'b1, "R7 flag while masked");
    check(irq_o, 1'b0, "R7 line masked");
    #1 irq_en = 1'b1; #1;
    check(irq_o, 1'b1, "R7 line follows enable");
    #1 irq_en = 1'b0; #1;
    check(irq_o, 1'b0, "R7 line drops with enable");
    irq_en = 1'b1;

    // R9: long run past the counter range
    persist_cfg = 4'd15;
    clear();
    for (int k = 0; k < 20; k++) begin
      send(16'h0000, 1'b0);
      if (k >= 14) check(irq_flag, 1'b1, "R9 long run holds");
    end

    idle(2);
    finish_run();
  end
endmodule